// File: doc/BRIEF.md
# Pixel-Clock PLL Reload Sequencer

This block rewrites the control word of a pixel-clock PLL without letting an unstable clock reach the display pipeline. A host presents a 32-bit target word and pulses a start request. The sequencer first routes the PLL output around the PLL. It then parks the PLL in power-down with its internal bypass engaged and loads the new configuration. After that it brings the PLL back in three timed stages: power-up, release of the internal bypass, and release of the output bypass. A settle interval of about one millisecond separates each stage from the next.

The block owns the control register. Every value it writes appears on a 32-bit word output together with a one-cycle strobe, so downstream logic sees the exact order of the writes. A busy flag covers the whole sequence. A one-cycle done pulse follows the last write. The settle interval is counted in reference-clock cycles, derived from a frequency parameter given in kHz.

Top module: `pll_reload_seq`

## Requirements
- R1: After reset the word output is 0 and busy, done and the write strobe are all low.
- R2: The cycle after an accepted start, a write presents the current word with bit 30 (active-low output bypass) cleared and every other bit unchanged.
- R3: On the next cycle, a write presents 32'h2100_0000: bit 24 (power-down) and bit 29 (internal bypass) set, all other bits zero.
- R4: On the cycle after that, a write presents the target word exactly as it was sampled with the start request.
- R5: One settle interval after the target write, a write presents the target with bit 24 cleared.
- R6: One settle interval later, a write presents the previous word with bit 29 also cleared.
- R7: One settle interval later, a write presents the previous word with bit 30 set. This is the last write of the sequence.
- R8: A settle interval is REF_CLK_KHZ reference cycles, which is one millisecond. It is measured from strobe to strobe.
- R9: Each write is marked by a strobe that lasts one cycle, and a sequence produces exactly six strobes. No strobe occurs outside a sequence.
- R10: Busy is high from the first write through the last write. A start request while busy is ignored and does not change the target or the order of the writes.
- R11: Done is high for exactly one cycle, the cycle after the last write, and busy is low in that cycle. A start in that same cycle is accepted.
- R12: Asserting the active-low reset in the middle of a sequence immediately returns the block to idle, with the word at 0 and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| start_i | input | 1 | Request to load target_i |
| target_i | input | 32 | New PLL configuration word, sampled with an accepted start |
| pll_word_o | output | 32 | Current PLL control register value |
| pll_wr_o | output | 1 | One-cycle strobe marking a write of pll_word_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
Two events can fall in the same cycle: the done pulse of one sequence and the start request of the next. The bench waits until it sees done high and drives start within that same cycle. It then expects the first write of the new sequence on the following cycle. That write must carry the previous sequence's final word with bit 30 cleared. A second probe drives start while a settle wait is running. The scoreboard must then see the original six words at the original cycles, and nothing else.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BIT_PWRDN  = 24;
  localparam int unsigned BIT_IBYP   = 29;
  localparam int unsigned BIT_OBYP_N = 30;

  localparam logic [WORD_W-1:0] MASK_PWRDN  = WORD_W'(1) << BIT_PWRDN;
  localparam logic [WORD_W-1:0] MASK_IBYP   = WORD_W'(1) << BIT_IBYP;
  localparam logic [WORD_W-1:0] MASK_OBYP_N = WORD_W'(1) << BIT_OBYP_N;
  localparam logic [WORD_W-1:0] PARK_WORD   = MASK_PWRDN | MASK_IBYP;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PARK    = 3'd1,
    ST_LOAD    = 3'd2,
    ST_WAIT_PU = 3'd3,
    ST_WAIT_IB = 3'd4,
    ST_WAIT_OB = 3'd5,
    ST_FINISH  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = run_i && (cnt_q == '0);

  // R8: a load always restarts the full interval
  assert_timer_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == RELOAD));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] target_i,
  input  logic              settle_done_i,
  output logic              settle_load_o,
  output logic              settle_run_o,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_o,
  output logic              busy_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [WORD_W-1:0] word_q, word_d, tgt_q;
  logic              word_en, tgt_en;
  logic              wr_q, wr_d;
  logic              done_q, done_d;

  always_comb begin
    state_d       = state_q;
    word_d        = word_q;
    word_en       = 1'b0;
    tgt_en        = 1'b0;
    wr_d          = 1'b0;
    done_d        = 1'b0;
    settle_load_o = 1'b0;
    settle_run_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          word_d  = word_q & ~MASK_OBYP_N;
          word_en = 1'b1;
          wr_d    = 1'b1;
          tgt_en  = 1'b1;
          state_d = ST_PARK;
        end
      end
      ST_PARK: begin
        word_d  = PARK_WORD;
        word_en = 1'b1;
        wr_d    = 1'b1;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        word_d        = tgt_q;
        word_en       = 1'b1;
        wr_d          = 1'b1;
        settle_load_o = 1'b1;
        state_d       = ST_WAIT_PU;
      end
      ST_WAIT_PU: begin
        settle_run_o = 1'b1;
        if (settle_done_i) begin
          word_d        = tgt_q & ~MASK_PWRDN;
          word_en       = 1'b1;
          wr_d          = 1'b1;
          settle_load_o = 1'b1;
          state_d       = ST_WAIT_IB;
        end
      end
      ST_WAIT_IB: begin
        settle_run_o = 1'b1;
        if (settle_done_i) begin
          word_d        = word_q & ~MASK_IBYP;
          word_en       = 1'b1;
          wr_d          = 1'b1;
          settle_load_o = 1'b1;
          state_d       = ST_WAIT_OB;
        end
      end
      ST_WAIT_OB: begin
        settle_run_o = 1'b1;
        if (settle_done_i) begin
          word_d  = word_q | MASK_OBYP_N;
          word_en = 1'b1;
          wr_d    = 1'b1;
          state_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (tgt_en) begin
      tgt_q <= target_i;
    end
  end

  assign word_o = word_q;
  assign wr_o   = wr_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R2: the first write of a sequence has the output bypass engaged
  assert_first_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=> (wr_q && !word_q[BIT_OBYP_N]));

  // R5: the power-up write leaves the PLL out of power-down
  assert_powerup_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && state_q == ST_WAIT_IB) |-> !word_q[BIT_PWRDN]);

  // R7: done follows a write that released the output bypass
  assert_live_before_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(wr_q) && $past(word_q[BIT_OBYP_N])));

  // R11: done lasts one cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: the target is frozen while a sequence runs
  assert_target_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(tgt_q));

endmodule

// File: rtl/pll_reload_seq.sv
module pll_reload_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned REF_CLK_KHZ = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] target_i,
  output logic [31:0] pll_word_o,
  output logic        pll_wr_o,
  output logic        busy_o,
  output logic        done_o
);

  // one millisecond of reference clock, never below one cycle
  localparam int unsigned SETTLE_CYCLES = (REF_CLK_KHZ > 0) ? REF_CLK_KHZ : 1;

  logic rst_int_n;
  logic settle_load, settle_run, settle_done;

  pll_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  pll_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (settle_load),
    .run_i     (settle_run),
    .expired_o (settle_done)
  );

  pll_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_i       (start_i),
    .target_i      (target_i),
    .settle_done_i (settle_done),
    .settle_load_o (settle_load),
    .settle_run_o  (settle_run),
    .word_o        (pll_word_o),
    .wr_o          (pll_wr_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  // R9: no strobe outside a sequence
  assert_no_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> !pll_wr_o);

  // R11: busy is low while done pulses
  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !busy_o);

endmodule

// File: tb/tb_pll_reload_seq.sv
module tb_pll_reload_seq;

  localparam int KHZ = 12;
  localparam int S   = KHZ;
  localparam logic [31:0] B24 = 32'h0100_0000;
  localparam logic [31:0] B29 = 32'h2000_0000;
  localparam logic [31:0] B30 = 32'h4000_0000;

  typedef struct {
    bit          is_done;
    logic [31:0] word;
    int          cyc;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] target_i = '0;
  logic [31:0] pll_word_o;
  logic        pll_wr_o, busy_o, done_o;

  exp_t        q[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] model_word = '0;

  pll_reload_seq #(.REF_CLK_KHZ(KHZ)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
    .pll_word_o(pll_word_o), .pll_wr_o(pll_wr_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor: pops one expected item for every strobe or done pulse
  always @(negedge clk) begin
    if (rst_n && (pll_wr_o || done_o)) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected strobe/done", {30'd0, pll_wr_o, done_o}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(done_o == e.is_done && pll_wr_o == !e.is_done, e.req, "event kind",
              {30'd0, pll_wr_o, done_o}, {30'd0, !e.is_done, e.is_done});
        if (!e.is_done)
          check(pll_word_o == e.word, e.req, "written word", pll_word_o, e.word);
        else
          check(!busy_o, "R11", "busy during done", {31'd0, busy_o}, 32'd0);
        check(cyc == e.cyc, e.req, "cycle of event (R8 spacing)", cyc, e.cyc);
      end
    end
  end

  // driver: pushes the expected trace and pulses start
  task automatic run_seq(input logic [31:0] tgt, input bit now, input bit probe);
    int c;
    logic [31:0] w;
    if (!now) @(negedge clk);
    c = cyc;
    w = model_word & ~B30;
    q.push_back('{1'b0, w,             c + 1,         "R2"});
    q.push_back('{1'b0, 32'h2100_0000, c + 2,         "R3"});
    q.push_back('{1'b0, tgt,           c + 3,         "R4"});
    w = tgt & ~B24;
    q.push_back('{1'b0, w,             c + 3 + S,     "R5"});
    w = w & ~B29;
    q.push_back('{1'b0, w,             c + 3 + 2*S,   "R6"});
    w = w | B30;
    q.push_back('{1'b0, w,             c + 3 + 3*S,   "R7"});
    q.push_back('{1'b1, 32'd0,         c + 4 + 3*S,   "R11"});
    model_word = w;
    start_i  = 1'b1;
    target_i = tgt;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o, "R10", "busy after start", {31'd0, busy_o}, 32'd1);
    if (probe) begin
      repeat (4) @(negedge clk);
      start_i  = 1'b1;
      target_i = ~tgt;   // R10: must be ignored
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, "R10", "busy during ignored start", {31'd0, busy_o}, 32'd1);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(pll_word_o == 32'd0, "R1", "word after reset", pll_word_o, 32'd0);
    check({busy_o, done_o, pll_wr_o} == 3'b000, "R1", "flags after reset",
          {29'd0, busy_o, done_o, pll_wr_o}, 32'd0);

    run_seq(32'hA5A5_A5A5, 1'b0, 1'b1);
    wait_done();
    @(negedge clk);
    check(!done_o, "R11", "done width", {31'd0, done_o}, 32'd0);

    run_seq(32'hFFFF_FFFF, 1'b0, 1'b0);
    wait_done();
    // R11: start in the done cycle is accepted
    run_seq(32'h0000_0000, 1'b1, 1'b0);
    wait_done();
    run_seq(32'h3E12_7C40, 1'b1, 1'b1);
    wait_done();
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9", "leftover expected events", q.size(), 32'd0);

    // R12: reset in the middle of a sequence
    run_seq(32'h1234_5678, 1'b0, 1'b0);
    repeat (S) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pll_word_o == 32'd0, "R12", "word after abort", pll_word_o, 32'd0);
    check(!busy_o && !done_o, "R12", "flags after abort", {30'd0, busy_o, done_o}, 32'd0);
    q.delete();
    model_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !pll_wr_o, "R12", "idle after abort release",
          {30'd0, busy_o, pll_wr_o}, 32'd0);
    run_seq(32'h6F00_00C3, 1'b0, 1'b0);
    wait_done();
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9", "leftover after final run", q.size(), 32'd0);
    summary();
  end

endmodule